// File: doc/BRIEF.md
# CHS/LBA Sector Address Sequencer

This block holds the current media address of a single ATA device and keeps it consistent with the
device's notion of geometry. The address lives in three task-file fields (cylinder, head, sector).
A mode bit says how to read them: as a cylinder/head/sector triple, or as a 28-bit logical block
address packed as `{head[3:0], cylinder[15:0], sector[7:0]}`. A registered output gives the linear
sector number that a media back end would use for the current address in either mode.

The host-side front end presents a command strobe with its opcode and the task-file fields. The
block captures the fields, decodes the command class and does one of four things:

- for a geometry command, latches sectors-per-track and heads-per-cylinder;
- for a seek, checks the address against the geometry;
- for a media transfer, arms a sector countdown;
- for a diagnostics command, clears the geometry.

During a transfer, each sector-done pulse counts the transfer down. The address steps to the next
sector only while sectors remain.

A separate load request writes a linear sector number back into the fields. In CHS mode this takes
two passes of a shared iterative divider. The block shows a busy flag while dividing and a one-cycle
done pulse when the fields are written.

Top module: `ata_addr_seq`

## Requirements
- R1: After synchronous reset: cylinder 0, head 0, sector 1, CHS mode, remaining count 0, ID-not-found flag clear, busy low, sectors-per-track (spt) 0 and heads-per-cylinder (hpc) 0.
- R2: Opcode 0x91 sets spt to the sector-count field and hpc to the head field plus one, but only while spt is 0; otherwise it leaves the geometry unchanged. Opcode 0x90 clears spt and hpc to 0.
- R3: Media opcodes are 0x20–0x3F, 0x40, 0x41, 0x50, 0xC4, 0xC5 and 0xC8–0xCB. A media opcode issued in CHS mode while spt is 0 sets the ID-not-found flag and leaves the remaining count at 0. Otherwise it clears the flag and loads the count from the sector-count field, where 0 means 256. Every accepted command other than a failing media command or a failing seek clears the flag.
- R4: Opcodes 0x70–0x7F (seek) in CHS mode set the ID-not-found flag when any of these holds: cylinder ≥ NUM_TRACKS, head ≥ hpc, sector = 0, or sector > spt. In LBA mode a seek never sets the flag.
- R5: In CHS mode the linear output equals (cylinder·hpc + head)·spt + (sector − 1), with sector 0 counted as offset 0. It is registered one clock after the fields change.
- R6: In LBA mode the linear output equals `{head, cylinder, sector}`, with bit 27 at head bit 3 and bit 0 at sector bit 0.
- R7: A sector-done pulse while the remaining count is non-zero decrements the count. The address advances only if the new count is non-zero. A pulse at count 0 changes nothing.
- R8: A CHS step increments the sector. When the result is 0 or spt+1, the sector becomes 1 and the head increments. When the new head is 0 (4-bit wrap) or equals hpc, the head becomes 0 and the cylinder increments.
- R9: An LBA step adds one to the 28-bit address, modulo 2^28.
- R10: A load request in CHS mode with spt ≠ 0 raises busy. It then writes cylinder = n / (hpc·spt), head = (n mod hpc·spt) / spt and sector = (n mod spt) + 1, and pulses load-done for one cycle.
- R11: A load request in LBA mode writes the fields from n directly (bits 27:24, 23:8, 7:0) and pulses load-done with no busy period. A load request in CHS mode while spt is 0 sets the ID-not-found flag, leaves the fields unchanged and pulses load-done.
- R12: Priority within one cycle is command strobe, then load request, then sector-done; a lower one is ignored in that cycle. While busy, commands, loads and sector-done pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 8 | Command opcode |
| tf_lba | input | 1 | Addressing mode for the command (1 = LBA) |
| tf_cyl | input | 16 | Cylinder field / LBA bits 23:8 |
| tf_head | input | 4 | Head field / LBA bits 27:24 |
| tf_sec | input | 8 | Sector field / LBA bits 7:0 |
| tf_count | input | 8 | Sector-count field |
| sec_done | input | 1 | One 512-byte sector completed |
| lin_load | input | 1 | Load fields from a linear sector number |
| lin_value | input | 28 | Linear sector number to load |
| cur_cyl | output | 16 | Current cylinder field |
| cur_head | output | 4 | Current head field |
| cur_sec | output | 8 | Current sector field |
| cur_lba | output | 1 | Current addressing mode |
| remain_cnt | output | 9 | Sectors left in the transfer |
| idnf | output | 1 | ID-not-found error flag |
| lin_sector | output | 28 | Linear sector of the current address |
| busy | output | 1 | Linear-to-CHS division in progress |
| load_done | output | 1 | One-cycle pulse when a load finishes |

## Verification
A command strobe and a sector-done pulse can land in the same cycle. So can a command strobe and a
load request, and a load request and a sector-done pulse. The bench raises each pair together for
one clock. It then judges the outcome from the remaining count, the busy flag and the fields: the
higher-priority action must be fully visible and the lower one must leave no trace. A fourth case
raises a command and a sector-done pulse while a division is running. Both must be dropped, and the
count and the division result must come out unchanged.

// File: rtl/ata_addr_pkg.sv
package ata_addr_pkg;
  localparam int CYL_W  = 16;
  localparam int HEAD_W = 4;
  localparam int SEC_W  = 8;
  localparam int HPC_W  = HEAD_W + 1;
  localparam int CNT_W  = SEC_W + 1;
  localparam int LBA_W  = CYL_W + HEAD_W + SEC_W;

  // packed order gives the LBA bit layout {27:24, 23:8, 7:0}
  typedef struct packed {
    logic [HEAD_W-1:0] head;
    logic [CYL_W-1:0]  cyl;
    logic [SEC_W-1:0]  sec;
  } tf_addr_t;

  typedef enum logic [2:0] {
    OPC_OTHER, OPC_MEDIA, OPC_SEEK, OPC_GEOM, OPC_DIAG
  } op_class_e;

  typedef enum logic [1:0] {
    LD_IDLE, LD_SPT, LD_HPC
  } ld_state_e;

  function automatic op_class_e classify_op(input logic [7:0] op);
    op_class_e c;
    c = OPC_OTHER;
    if (op == 8'h91)                 c = OPC_GEOM;
    else if (op == 8'h90)            c = OPC_DIAG;
    else if (op[7:4] == 4'h7)        c = OPC_SEEK;
    else if (op[7:5] == 3'b001)      c = OPC_MEDIA;
    else if (op == 8'h40 || op == 8'h41 || op == 8'h50 ||
             op == 8'hC4 || op == 8'hC5 || op[7:2] == 6'b110010)
      c = OPC_MEDIA;
    return c;
  endfunction

  function automatic tf_addr_t chs_advance(input tf_addr_t a,
                                           input logic [SEC_W-1:0] spt,
                                           input logic [HPC_W-1:0] hpc);
    tf_addr_t r;
    logic [SEC_W:0] ns;
    logic [HEAD_W-1:0] nh;
    r  = a;
    ns = {1'b0, a.sec} + 1'b1;
    nh = a.head + 1'b1;
    if (ns[SEC_W-1:0] == '0 || ns == ({1'b0, spt} + 1'b1)) begin
      r.sec = SEC_W'(1);
      if (nh == '0 || {1'b0, nh} == hpc) begin
        r.head = '0;
        r.cyl  = a.cyl + 1'b1;
      end else begin
        r.head = nh;
      end
    end else begin
      r.sec = ns[SEC_W-1:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/ata_geom.sv
module ata_geom
  import ata_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              geom_fire,
  input  logic              diag_fire,
  input  logic [SEC_W-1:0]  cnt_in,
  input  logic [HEAD_W-1:0] head_in,
  output logic [SEC_W-1:0]  spt_o,
  output logic [HPC_W-1:0]  hpc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      spt_o <= '0;
      hpc_o <= '0;
    end else if (diag_fire) begin
      spt_o <= '0;
      hpc_o <= '0;
    end else if (geom_fire && spt_o == '0) begin
      spt_o <= cnt_in;
      hpc_o <= {1'b0, head_in} + 1'b1;
    end
  end

  // R2: geometry is frozen once spt is non-zero
  a_r2_geom_once: assert property (@(posedge clk) disable iff (rst)
    (geom_fire && !diag_fire && spt_o != '0) |=> ($stable(spt_o) && $stable(hpc_o)));
endmodule

// File: rtl/ata_lin_map.sv
module ata_lin_map
  import ata_addr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             lba_mode,
  input  tf_addr_t         addr,
  input  logic [SEC_W-1:0] spt,
  input  logic [HPC_W-1:0] hpc,
  output logic [LBA_W-1:0] lin_q
);
  localparam int PW = CYL_W + HPC_W + SEC_W + 1;

  logic [SEC_W-1:0] off;
  logic [PW-1:0]    prod;
  logic [LBA_W-1:0] lin_d;

  always_comb begin
    off   = (addr.sec == '0) ? '0 : addr.sec - 1'b1;
    prod  = (PW'(addr.cyl) * PW'(hpc) + PW'(addr.head)) * PW'(spt) + PW'(off);
    lin_d = lba_mode ? LBA_W'(addr) : prod[LBA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) lin_q <= '0;
    else     lin_q <= lin_d;
  end
endmodule

// File: rtl/ata_iter_div.sv
module ata_iter_div #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  d_q;
  logic [W:0]    sh;
  logic [W:0]    diff;
  logic          take;

  always_comb begin
    sh   = {rem, quot[W-1]};
    diff = sh - {1'b0, d_q};
    take = (sh >= {1'b0, d_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
      quot  <= '0;
      rem   <= '0;
      d_q   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        quot  <= dividend;
        rem   <= '0;
        d_q   <= divisor;
        cnt_q <= CW'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        quot  <= {quot[W-2:0], take};
        rem   <= take ? diff[W-1:0] : sh[W-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R10: a result only appears at the end of a busy period
  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
  // R10: remainder always below the latched divisor
  a_r10_rem_below_div: assert property (@(posedge clk) disable iff (rst)
    (done && d_q != '0) |-> (rem < d_q));
endmodule

// File: rtl/ata_addr_seq.sv
module ata_addr_seq
  import ata_addr_pkg::*;
#(
  parameter int NUM_TRACKS = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic              tf_lba,
  input  logic [CYL_W-1:0]  tf_cyl,
  input  logic [HEAD_W-1:0] tf_head,
  input  logic [SEC_W-1:0]  tf_sec,
  input  logic [SEC_W-1:0]  tf_count,
  input  logic              sec_done,
  input  logic              lin_load,
  input  logic [LBA_W-1:0]  lin_value,
  output logic [CYL_W-1:0]  cur_cyl,
  output logic [HEAD_W-1:0] cur_head,
  output logic [SEC_W-1:0]  cur_sec,
  output logic              cur_lba,
  output logic [CNT_W-1:0]  remain_cnt,
  output logic              idnf,
  output logic [LBA_W-1:0]  lin_sector,
  output logic              busy,
  output logic              load_done
);
  tf_addr_t         addr_q;
  logic             lba_q;
  logic [CNT_W-1:0] remain_q;
  logic             idnf_q;
  ld_state_e        ld_q;
  logic [SEC_W-1:0] sec_hold_q;
  logic             load_done_q;

  logic [SEC_W-1:0] spt;
  logic [HPC_W-1:0] hpc;
  op_class_e        op_cls;
  logic             idle, cmd_fire, load_fire, step_fire;
  logic             seek_bad;
  tf_addr_t         cmd_addr;

  logic             div_start, div_busy, div_done;
  logic [LBA_W-1:0] div_dvd, div_dvs, div_quot, div_rem;

  always_comb begin
    op_cls    = classify_op(cmd_op);
    idle      = (ld_q == LD_IDLE);
    cmd_fire  = cmd_valid && idle;
    load_fire = lin_load && idle && !cmd_valid;
    step_fire = sec_done && idle && !cmd_valid && !lin_load && (remain_q != '0);
    cmd_addr  = '{head: tf_head, cyl: tf_cyl, sec: tf_sec};
    seek_bad  = !tf_lba && ((32'(tf_cyl) >= NUM_TRACKS) || ({1'b0, tf_head} >= hpc) ||
                            (tf_sec == '0) || (tf_sec > spt));
    div_start = (load_fire && !lba_q && spt != '0) || (ld_q == LD_SPT && div_done);
    div_dvd   = (ld_q == LD_SPT) ? div_quot : lin_value;
    div_dvs   = (ld_q == LD_SPT) ? LBA_W'(hpc) : LBA_W'(spt);
  end

  ata_geom geom_i (
    .clk       (clk),
    .rst       (rst),
    .geom_fire (cmd_fire && op_cls == OPC_GEOM),
    .diag_fire (cmd_fire && op_cls == OPC_DIAG),
    .cnt_in    (tf_count),
    .head_in   (tf_head),
    .spt_o     (spt),
    .hpc_o     (hpc)
  );

  ata_lin_map map_i (
    .clk      (clk),
    .rst      (rst),
    .lba_mode (lba_q),
    .addr     (addr_q),
    .spt      (spt),
    .hpc      (hpc),
    .lin_q    (lin_sector)
  );

  ata_iter_div #(.W(LBA_W)) div_i (
    .clk      (clk),
    .rst      (rst),
    .start    (div_start),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .busy     (div_busy),
    .done     (div_done),
    .quot     (div_quot),
    .rem      (div_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q      <= '{head: '0, cyl: '0, sec: SEC_W'(1)};
      lba_q       <= 1'b0;
      remain_q    <= '0;
      idnf_q      <= 1'b0;
      ld_q        <= LD_IDLE;
      sec_hold_q  <= '0;
      load_done_q <= 1'b0;
    end else begin
      load_done_q <= 1'b0;
      if (cmd_fire) begin
        addr_q <= cmd_addr;
        lba_q  <= tf_lba;
        case (op_cls)
          OPC_MEDIA: begin
            if (!tf_lba && spt == '0) begin
              idnf_q   <= 1'b1;
              remain_q <= '0;
            end else begin
              idnf_q   <= 1'b0;
              remain_q <= (tf_count == '0) ? CNT_W'(256) : {1'b0, tf_count};
            end
          end
          OPC_SEEK: begin
            idnf_q   <= seek_bad;
            remain_q <= '0;
          end
          default: begin
            idnf_q   <= 1'b0;
            remain_q <= '0;
          end
        endcase
      end else if (load_fire) begin
        if (lba_q) begin
          addr_q      <= tf_addr_t'(lin_value);
          load_done_q <= 1'b1;
        end else if (spt == '0) begin
          idnf_q      <= 1'b1;
          load_done_q <= 1'b1;
        end else begin
          ld_q <= LD_SPT;
        end
      end else if (step_fire) begin
        remain_q <= remain_q - 1'b1;
        if (remain_q != CNT_W'(1))
          addr_q <= lba_q ? tf_addr_t'(LBA_W'(addr_q) + 1'b1) : chs_advance(addr_q, spt, hpc);
      end

      case (ld_q)
        LD_SPT: if (div_done) begin
          sec_hold_q <= div_rem[SEC_W-1:0] + 1'b1;
          ld_q       <= LD_HPC;
        end
        LD_HPC: if (div_done) begin
          addr_q.cyl  <= div_quot[CYL_W-1:0];
          addr_q.head <= div_rem[HEAD_W-1:0];
          addr_q.sec  <= sec_hold_q;
          ld_q        <= LD_IDLE;
          load_done_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign cur_cyl    = addr_q.cyl;
  assign cur_head   = addr_q.head;
  assign cur_sec    = addr_q.sec;
  assign cur_lba    = lba_q;
  assign remain_cnt = remain_q;
  assign idnf       = idnf_q;
  assign busy       = !idle;
  assign load_done  = load_done_q;

  // R7: the count only grows through a command
  a_r7_count_no_grow: assert property (@(posedge clk) disable iff (rst)
    !cmd_fire |=> (remain_q <= $past(remain_q)));
  // R7: the final sector leaves the address in place
  a_r7_last_holds: assert property (@(posedge clk) disable iff (rst)
    (step_fire && remain_q == CNT_W'(1)) |=> $stable(addr_q));
  // R8: a CHS step keeps an in-range sector in range
  a_r8_sec_in_range: assert property (@(posedge clk) disable iff (rst)
    (step_fire && !lba_q && addr_q.sec != '0 && addr_q.sec <= spt)
      |=> (addr_q.sec != '0 && addr_q.sec <= spt));
  // R12: nothing touches the count while a division runs
  a_r12_busy_frozen: assert property (@(posedge clk) disable iff (rst)
    !idle |=> $stable(remain_q));
  // R10: the load pulse only closes a division or a direct load
  a_r10_done_source: assert property (@(posedge clk) disable iff (rst)
    load_done_q |-> ($past(load_fire) || ($past(ld_q) == LD_HPC)));
endmodule

// File: tb/ata_addr_seq_tb_top.sv
module ata_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = '0;
  logic        tf_lba = 1'b0;
  logic [15:0] tf_cyl = '0;
  logic [3:0]  tf_head = '0;
  logic [7:0]  tf_sec = '0;
  logic [7:0]  tf_count = '0;
  logic        sec_done = 1'b0;
  logic        lin_load = 1'b0;
  logic [27:0] lin_value = '0;
  logic [15:0] cur_cyl;
  logic [3:0]  cur_head;
  logic [7:0]  cur_sec;
  logic        cur_lba;
  logic [8:0]  remain_cnt;
  logic        idnf;
  logic [27:0] lin_sector;
  logic        busy;
  logic        load_done;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  ata_addr_seq #(.NUM_TRACKS(1024)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic chk_addr(input string tag, input int c, input int h, input int s);
    chk({tag, " cyl"},  32'(cur_cyl),  32'(c));
    chk({tag, " head"}, 32'(cur_head), 32'(h));
    chk({tag, " sec"},  32'(cur_sec),  32'(s));
  endtask

  task automatic issue(input logic [7:0] op, input logic lba, input logic [15:0] c,
                       input logic [3:0] h, input logic [7:0] s, input logic [7:0] n);
    @(negedge clk);
    cmd_op = op; tf_lba = lba; tf_cyl = c; tf_head = h; tf_sec = s; tf_count = n;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic step();
    @(negedge clk);
    sec_done = 1'b1;
    @(negedge clk);
    sec_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_load(input logic [27:0] n, output logic saw_busy);
    @(negedge clk);
    lin_value = n;
    lin_load = 1'b1;
    @(negedge clk);
    lin_load = 1'b0;
    saw_busy = busy;
    for (int i = 0; i < 200 && !load_done; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_addr("R1 reset", 0, 0, 1);
    chk("R1 lba", 32'(cur_lba), 0);
    chk("R1 remain", 32'(remain_cnt), 0);
    chk("R1 idnf", 32'(idnf), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 lin", 32'(lin_sector), 0);

    // R3 media before geometry
    issue(8'h20, 0, 0, 0, 1, 4);
    chk("R3 idnf no geom", 32'(idnf), 1);
    chk("R3 remain no geom", 32'(remain_cnt), 0);
    issue(8'h00, 0, 0, 0, 1, 0);
    chk("R3 idnf cleared", 32'(idnf), 0);

    // R11 load refused without geometry
    do_load(28'd100, b);
    chk("R11 refused idnf", 32'(idnf), 1);
    chk_addr("R11 refused", 0, 0, 1);

    // R2 geometry latch once
    issue(8'h91, 0, 0, 2, 1, 5);
    issue(8'h91, 0, 0, 7, 1, 9);
    issue(8'h00, 0, 1, 0, 1, 0);
    chk("R2 geom once lin", 32'(lin_sector), 15);
    issue(8'h90, 0, 0, 0, 1, 0);
    issue(8'h91, 0, 0, 1, 1, 4);
    issue(8'h00, 0, 1, 1, 3, 0);
    chk("R2 after diag lin", 32'(lin_sector), 14);
    issue(8'h90, 0, 0, 0, 1, 0);
    issue(8'h91, 0, 0, 2, 1, 5);

    // R5 linear map sweep, spt 5 hpc 3
    for (int c = 0; c < 4; c++)
      for (int h = 0; h < 3; h++)
        for (int s = 0; s < 7; s++) begin
          issue(8'h00, 0, 16'(c), 4'(h), 8'(s), 0);
          chk("R5 chs lin", 32'(lin_sector), 32'((c * 3 + h) * 5 + ((s == 0) ? 0 : s - 1)));
        end

    // R7/R8 full 256-sector CHS countdown
    issue(8'h20, 0, 0, 0, 1, 0);
    chk("R3 count zero means 256", 32'(remain_cnt), 256);
    for (int k = 1; k <= 256; k++) begin
      int e;
      step();
      e = (k < 256) ? k : 255;
      chk("R7 remain", 32'(remain_cnt), 32'(256 - k));
      chk_addr("R8 step", e / 15, (e % 15) / 5, e % 5 + 1);
      chk("R5 step lin", 32'(lin_sector), 32'(e));
    end
    step();
    chk("R7 pulse at zero", 32'(remain_cnt), 0);
    chk_addr("R7 pulse at zero", 17, 0, 1);

    // R8 wrap through sector 0 and through head 4-bit overflow
    issue(8'h20, 0, 0, 0, 254, 3);
    step();
    chk_addr("R8 to 255", 0, 0, 255);
    step();
    chk_addr("R8 wrap via 0", 0, 1, 1);
    issue(8'h20, 0, 2, 15, 5, 2);
    step();
    chk_addr("R8 head overflow", 3, 0, 1);

    // R6/R9 LBA
    issue(8'h20, 1, 16'hFFFF, 0, 8'hFF, 3);
    chk("R6 lba lin", 32'(lin_sector), 32'h0FFFFFF);
    step();
    chk("R9 lba carry", 32'(lin_sector), 32'h1000000);
    chk_addr("R6 lba fields", 0, 1, 0);
    issue(8'h20, 1, 16'hFFFF, 4'hF, 8'hFF, 2);
    step();
    chk("R9 lba wrap", 32'(lin_sector), 0);
    chk("R7 remain lba", 32'(remain_cnt), 1);

    // R4 seek checks
    issue(8'h70, 0, 1023, 2, 5, 0); chk("R4 seek valid", 32'(idnf), 0);
    issue(8'h7F, 0, 1024, 0, 1, 0); chk("R4 seek cyl", 32'(idnf), 1);
    issue(8'h70, 0, 0, 3, 1, 0);    chk("R4 seek head", 32'(idnf), 1);
    issue(8'h70, 0, 0, 0, 0, 0);    chk("R4 seek sec0", 32'(idnf), 1);
    issue(8'h70, 0, 0, 0, 6, 0);    chk("R4 seek sec>spt", 32'(idnf), 1);
    issue(8'h70, 1, 2000, 9, 0, 0); chk("R4 seek lba", 32'(idnf), 0);

    // R10 linear-to-CHS load sweep
    issue(8'h00, 0, 0, 0, 1, 0);
    for (int n = 0; n < 64; n++) begin
      do_load(28'(n), b);
      chk("R10 busy seen", 32'(b), 1);
      chk_addr("R10 load", n / 15, (n % 15) / 5, n % 5 + 1);
      chk("R10 lin back", 32'(lin_sector), 32'(n));
    end
    do_load(28'd983039, b);
    chk_addr("R10 load max", 65535, 2, 5);
    chk("R10 lin max", 32'(lin_sector), 983039);

    // R11 LBA load
    issue(8'h00, 1, 0, 0, 0, 0);
    do_load(28'hABCDEF1, b);
    chk("R11 no busy", 32'(b), 0);
    chk_addr("R11 lba load", 16'hBCDE, 4'hA, 8'hF1);
    chk("R11 lba lin", 32'(lin_sector), 32'hABCDEF1);

    // R12 commands and steps ignored while dividing
    issue(8'h20, 0, 0, 0, 1, 5);
    @(negedge clk);
    lin_value = 28'd17; lin_load = 1'b1;
    @(negedge clk);
    lin_load = 1'b0; sec_done = 1'b1; cmd_valid = 1'b1;
    cmd_op = 8'h20; tf_lba = 0; tf_cyl = 9; tf_head = 1; tf_sec = 2; tf_count = 9;
    @(negedge clk);
    sec_done = 1'b0; cmd_valid = 1'b0;
    for (int i = 0; i < 200 && !load_done; i++) @(negedge clk);
    @(negedge clk);
    chk("R12 busy remain", 32'(remain_cnt), 5);
    chk_addr("R12 busy load", 1, 0, 3);

    // R12 command beats step
    @(negedge clk);
    cmd_op = 8'h20; tf_lba = 0; tf_cyl = 4; tf_head = 1; tf_sec = 2; tf_count = 7;
    cmd_valid = 1'b1; sec_done = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; sec_done = 1'b0;
    chk("R12 cmd over step", 32'(remain_cnt), 7);
    chk_addr("R12 cmd over step", 4, 1, 2);

    // R12 command beats load
    @(negedge clk);
    cmd_op = 8'h00; tf_cyl = 6; tf_head = 2; tf_sec = 3;
    cmd_valid = 1'b1; lin_load = 1'b1; lin_value = 28'd40;
    @(negedge clk);
    cmd_valid = 1'b0; lin_load = 1'b0;
    chk("R12 cmd over load busy", 32'(busy), 0);
    chk_addr("R12 cmd over load", 6, 2, 3);

    // R12 load beats step
    issue(8'h20, 1, 0, 0, 5, 4);
    @(negedge clk);
    lin_value = 28'h0000123; lin_load = 1'b1; sec_done = 1'b1;
    @(negedge clk);
    lin_load = 1'b0; sec_done = 1'b0;
    chk("R12 load over step remain", 32'(remain_cnt), 4);
    chk_addr("R12 load over step", 16'h0001, 0, 8'h23);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule